// File: doc/BRIEF.md
# Three-Channel Command/Reply Mailbox

This block carries short messages between a host processor and a DSP over three independent channels. Each channel has two 16-bit registers. The host writes a command register and the DSP reads it. The DSP writes a reply register and the host reads it.

A pair of handshake flags tracks each channel. The command flag reads 1 while a command is still unread by the DSP. The reply flag reads 0 once the DSP has put down a fresh reply, and returns to 1 when the host collects it. The host sees all six flags in one 16-bit status word. A single interrupt line tells the host that a fresh reply is waiting on any channel whose interrupt it has enabled.

Each side has one channel select and plain single-cycle strobes, so each side touches at most one channel per cycle. The read data on both sides is combinational from the stored registers. Register and flag updates become visible on the clock edge that samples the strobe.

Top module: `hdsp_mailbox`

## Requirements
- R1: After reset, all command and reply registers hold 0, all six handshake flags read 1, and `reply_irq` is 0.
- R2: A host command strobe on channel c (0..2) stores `host_wdata` as that channel's command. On the next clock edge it sets status bit 13+c to 1 (unread).
- R3: While `dsp_ch` selects channel c, `dsp_cmd_rdata` shows that channel's command in the same cycle. A DSP command-read strobe clears status bit 13+c to 0 on the next edge.
- R4: A DSP reply strobe on channel c stores `dsp_wdata` as that channel's reply. On the next edge it clears status bit 10+c to 0 (fresh reply).
- R5: While `host_ch` selects channel c, `host_rep_rdata` shows that channel's reply in the same cycle. A host reply-read strobe sets status bit 10+c back to 1 on the next edge.
- R6: A host command write and a DSP command read on the same channel in the same cycle leave status bit 13+c at 1, and the command holds the newly written data.
- R7: A DSP reply write and a host reply read on the same channel in the same cycle leave status bit 10+c at 0, and the reply holds the newly written data.
- R8: `reply_irq` is 1 exactly when, for some channel c, `irq_en[c]` is 1 and status bit 10+c is 0. The input `irq_en[c]` enables channel c.
- R9: A channel select of 3 makes every strobe on that side have no effect, and the read data on that side is 0.
- R10: Status bits 0 to 9 always read 0.
- R11: A strobe on one channel changes no register or flag of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ch | input | 2 | Host-side channel select (0..2 valid) |
| host_cmd_wr | input | 1 | Host writes the command register of `host_ch` |
| host_wdata | input | 16 | Host command data |
| host_rep_rd | input | 1 | Host reads the reply register of `host_ch` |
| host_rep_rdata | output | 16 | Reply register of `host_ch` |
| dsp_ch | input | 2 | DSP-side channel select (0..2 valid) |
| dsp_cmd_rd | input | 1 | DSP reads the command register of `dsp_ch` |
| dsp_cmd_rdata | output | 16 | Command register of `dsp_ch` |
| dsp_rep_wr | input | 1 | DSP writes the reply register of `dsp_ch` |
| dsp_wdata | input | 16 | DSP reply data |
| irq_en | input | 3 | Per-channel reply interrupt enable |
| status | output | 16 | Handshake flags: bits 10..12 reply, bits 13..15 command |
| reply_irq | output | 1 | Reply interrupt to the host |

## Verification
The assertions assume one strobe of each kind per side per cycle, with each strobe lasting one cycle. Strobes carrying an out-of-range select are allowed: the slot assertions then expect every register to hold. The stimulus is driven on the falling edge and covers every combination of host channel, DSP channel, the four strobes and the eight enable patterns, including select 3 and same-channel collisions. It therefore stays inside these assumptions while reaching every ordering that the flag rules distinguish.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NUM_CH   = 3;
  localparam int SEL_W    = 2;
  localparam int STAT_W   = 16;
  localparam int REP_LSB  = 10;
  localparam int CMD_LSB  = 13;

  typedef logic [NUM_CH-1:0] ch_vec_t;

  // Place the six handshake flags at their fixed status positions.
  function automatic logic [STAT_W-1:0] pack_status(ch_vec_t rep_idle, ch_vec_t cmd_unread);
    logic [STAT_W-1:0] s;
    s = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      s[REP_LSB+i] = rep_idle[i];
      s[CMD_LSB+i] = cmd_unread[i];
    end
    return s;
  endfunction

  // A reply flag of 0 means a fresh reply is waiting.
  function automatic logic reply_pending(ch_vec_t en, ch_vec_t rep_idle);
    return |(en & ~rep_idle);
  endfunction
endpackage

// File: rtl/mbx_sel_decode.sv
module mbx_sel_decode
  import mbx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             strobe,
  output ch_vec_t          hit
);
  always_comb begin
    hit = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (strobe && sel == SEL_W'(i)) hit[i] = 1'b1;
  end

  // R9
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel >= SEL_W'(NUM_CH)) |-> (hit == '0));

  // R11
  one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/mbx_cmd_slot.sv
module mbx_cmd_slot #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] data_o,
  output logic              unread_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o   <= '0;
      unread_o <= 1'b1;
    end else if (wr_en) begin
      data_o   <= wr_data;
      unread_o <= 1'b1;
    end else if (rd_en) begin
      unread_o <= 1'b0;
    end
  end

  // R2
  cmd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (unread_o && data_o == $past(wr_data)));

  // R3
  cmd_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> !unread_o);

  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |=> ($stable(unread_o) && $stable(data_o)));
endmodule

// File: rtl/mbx_reply_slot.sv
module mbx_reply_slot #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] data_o,
  output logic              idle_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      idle_o <= 1'b1;
    end else if (wr_en) begin
      data_o <= wr_data;
      idle_o <= 1'b0;
    end else if (rd_en) begin
      idle_o <= 1'b1;
    end
  end

  // R4
  rep_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!idle_o && data_o == $past(wr_data)));

  // R5
  rep_collect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> idle_o);

  // R11
  rep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |=> ($stable(idle_o) && $stable(data_o)));
endmodule

// File: rtl/hdsp_mailbox.sv
module hdsp_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           host_ch,
  input  logic                 host_cmd_wr,
  input  logic [DATA_W-1:0]    host_wdata,
  input  logic                 host_rep_rd,
  output logic [DATA_W-1:0]    host_rep_rdata,
  input  logic [1:0]           dsp_ch,
  input  logic                 dsp_cmd_rd,
  output logic [DATA_W-1:0]    dsp_cmd_rdata,
  input  logic                 dsp_rep_wr,
  input  logic [DATA_W-1:0]    dsp_wdata,
  input  logic [2:0]           irq_en,
  output logic [15:0]          status,
  output logic                 reply_irq
);
  ch_vec_t host_wr_hit, host_rd_hit, dsp_rd_hit, dsp_wr_hit;
  ch_vec_t cmd_unread, rep_idle;
  logic [DATA_W-1:0] cmd_q [NUM_CH];
  logic [DATA_W-1:0] rep_q [NUM_CH];

  mbx_sel_decode u_dec_hw (.clk, .rst_n, .sel(host_ch), .strobe(host_cmd_wr), .hit(host_wr_hit));
  mbx_sel_decode u_dec_hr (.clk, .rst_n, .sel(host_ch), .strobe(host_rep_rd), .hit(host_rd_hit));
  mbx_sel_decode u_dec_dr (.clk, .rst_n, .sel(dsp_ch),  .strobe(dsp_cmd_rd),  .hit(dsp_rd_hit));
  mbx_sel_decode u_dec_dw (.clk, .rst_n, .sel(dsp_ch),  .strobe(dsp_rep_wr),  .hit(dsp_wr_hit));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    mbx_cmd_slot #(.DATA_W(DATA_W)) u_cmd (
      .clk, .rst_n,
      .wr_en(host_wr_hit[c]), .wr_data(host_wdata),
      .rd_en(dsp_rd_hit[c]),
      .data_o(cmd_q[c]), .unread_o(cmd_unread[c])
    );
    mbx_reply_slot #(.DATA_W(DATA_W)) u_rep (
      .clk, .rst_n,
      .wr_en(dsp_wr_hit[c]), .wr_data(dsp_wdata),
      .rd_en(host_rd_hit[c]),
      .data_o(rep_q[c]), .idle_o(rep_idle[c])
    );
  end

  always_comb begin
    host_rep_rdata = '0;
    dsp_cmd_rdata  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (host_ch == SEL_W'(i)) host_rep_rdata = rep_q[i];
      if (dsp_ch  == SEL_W'(i)) dsp_cmd_rdata  = cmd_q[i];
    end
  end

  assign status    = pack_status(rep_idle, cmd_unread);
  assign reply_irq = reply_pending(irq_en, rep_idle);

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !reply_irq);

  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&rep_idle) |-> !reply_irq);

  // R10
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[REP_LSB-1:0] == '0);
endmodule

// File: tb/hdsp_mailbox_tb.sv
module hdsp_mailbox_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic [1:0]  host_ch = 0, dsp_ch = 0;
  logic        host_cmd_wr = 0, host_rep_rd = 0, dsp_cmd_rd = 0, dsp_rep_wr = 0;
  logic [15:0] host_wdata = 0, dsp_wdata = 0;
  logic [2:0]  irq_en = 0;
  logic [15:0] host_rep_rdata, dsp_cmd_rdata, status;
  logic        reply_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_cmd [3];
  logic [15:0] m_rep [3];
  bit          m_unread [3];
  bit          m_idle [3];

  always #10 clk = ~clk;

  hdsp_mailbox u_dut (
    .clk, .rst_n, .host_ch, .host_cmd_wr, .host_wdata, .host_rep_rd, .host_rep_rdata,
    .dsp_ch, .dsp_cmd_rd, .dsp_cmd_rdata, .dsp_rep_wr, .dsp_wdata,
    .irq_en, .status, .reply_irq
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_status();
    logic [15:0] s = 0;
    for (int c = 0; c < 3; c++) begin
      if (m_idle[c])   s = s + (16'd1 << (10 + c));
      if (m_unread[c]) s = s + (16'd1 << (13 + c));
    end
    return s;
  endfunction

  function automatic bit exp_irq();
    bit r = 0;
    for (int c = 0; c < 3; c++) r = r | (irq_en[c] & ~m_idle[c]);
    return r;
  endfunction

  task automatic check_state();
    logic [15:0] s = exp_status();
    chk("R2", {13'd0, status[15:13]}, {13'd0, s[15:13]});
    chk("R4", {13'd0, status[12:10]}, {13'd0, s[12:10]});
    chk("R10", {6'd0, status[9:0]}, 16'd0);
    chk("R8", {15'd0, reply_irq}, {15'd0, exp_irq()});
  endtask

  // Drive one cycle from a falling edge; check reads before the edge, state after.
  task automatic cycle(input logic [1:0] hc, input bit hw, input bit hr, input logic [15:0] hd,
                       input logic [1:0] dc, input bit dr, input bit dw, input logic [15:0] dd,
                       input logic [2:0] en);
    host_ch = hc; host_cmd_wr = hw; host_rep_rd = hr; host_wdata = hd;
    dsp_ch = dc;  dsp_cmd_rd = dr;  dsp_rep_wr = dw;  dsp_wdata = dd;
    irq_en = en;
    #1;
    chk("R5", host_rep_rdata, (hc < 3) ? m_rep[hc] : 16'd0);
    chk("R3", dsp_cmd_rdata, (dc < 3) ? m_cmd[dc] : 16'd0);
    @(posedge clk);
    for (int c = 0; c < 3; c++) begin
      if (hw && hc == c) begin m_cmd[c] = hd; m_unread[c] = 1; end
      else if (dr && dc == c) m_unread[c] = 0;
      if (dw && dc == c) begin m_rep[c] = dd; m_idle[c] = 0; end
      else if (hr && hc == c) m_idle[c] = 1;
    end
    @(negedge clk);
    host_cmd_wr = 0; host_rep_rd = 0; dsp_cmd_rd = 0; dsp_rep_wr = 0;
    check_state();
  endtask

  initial begin
    for (int c = 0; c < 3; c++) begin
      m_cmd[c] = 0; m_rep[c] = 0; m_unread[c] = 1; m_idle[c] = 1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", status, 16'hFC00);
    chk("R1", {15'd0, reply_irq}, 16'd0);
    rst_n = 1;
    for (int c = 0; c < 3; c++) begin
      host_ch = 2'(c); dsp_ch = 2'(c); #1;
      chk("R1", host_rep_rdata, 16'd0);
      chk("R1", dsp_cmd_rdata, 16'd0);
    end
    @(negedge clk);

    // R6 collision on command channel 1
    cycle(2'd1, 1, 0, 16'hBEEF, 2'd1, 1, 0, 16'h0, 3'b000);
    chk("R6", {15'd0, status[14]}, 16'd1);
    host_ch = 1; dsp_ch = 1; #1;
    chk("R6", dsp_cmd_rdata, 16'hBEEF);
    @(negedge clk);

    // R7 collision on reply channel 2
    cycle(2'd2, 0, 1, 16'h0, 2'd2, 0, 1, 16'hC0DE, 3'b100);
    chk("R7", {15'd0, status[12]}, 16'd0);
    chk("R7", {15'd0, reply_irq}, 16'd1);

    // R9 select 3 ignored
    cycle(2'd3, 1, 1, 16'h1234, 2'd3, 1, 1, 16'h4321, 3'b111);
    chk("R9", status, exp_status());
    chk("R9", host_rep_rdata, 16'd0);

    // R11 channel 0 write leaves channels 1 and 2 untouched
    cycle(2'd0, 0, 0, 16'h0, 2'd0, 0, 1, 16'h7777, 3'b111);
    chk("R11", {14'd0, status[12:11]}, {14'd0, 2'b01});

    // Near-exhaustive sweep
    for (int k = 0; k < 2048; k++) begin
      logic [1:0] hc, dc;
      logic [3:0] ops;
      logic [2:0] en;
      hc = 2'(k % 4); dc = 2'((k / 4) % 4); ops = 4'((k / 16) % 16); en = 3'(k / 256);
      cycle(hc, ops[0], ops[1], 16'hA000 + 16'(k), dc, ops[2], ops[3], 16'h5000 + 16'(k), en);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule